// File: doc/BRIEF.md
# Serial SAR Converter Frame Reader

This block is the host end of a three-wire link to a differential successive-approximation converter. The three wires are an active-low select, a serial clock driven by the host, and one data line driven by the converter. On each accepted request it lowers select and runs one frame. It builds the serial clock from the system clock and takes one data bit on each rising serial-clock edge. It then raises select and returns the sample as a sign-extended two's-complement word. Select stays high between requests, which puts the converter in its low-power state. A guard interval with select high is kept before the reader accepts new work.

After reset the reader waits out the converter's power-up time. It then runs one throw-away frame before it reports ready. A request can ask for 12-bit or 10-bit samples. A request can also name a smaller number of data bits. In that case the reader releases select early, fills the missing low bits with zero and marks the sample as reduced.

Top module: `sar_adc_reader`

## Requirements
- R1: After reset, select and serial clock stay high and ready stays low for the power-up delay (PWRUP_US × CLK_MHZ system cycles). The reader then runs one 16-edge frame that yields no valid pulse, and only after that does ready rise.
- R2: A request is taken only while ready is high. A start pulse seen while ready is low starts no frame, and the mode and bit-count inputs are latched only when a request is taken.
- R3: The serial clock idles high whenever select is high. Within a frame every high or low phase lasts HALF = ceil(CLK_MHZ·1000 / (2·SCLK_KHZ)) system cycles, and the first falling edge comes HALF cycles after select falls.
- R4: Data is taken on rising serial-clock edges. A full frame has 16 rising edges. Frame positions 1 to 4 are padding and are ignored whatever their value. In 12-bit mode, positions 5 to 16 carry the sample MSB first.
- R5: In 12-bit mode (alt_res_i = 0) data_o is the 12-bit two's-complement sample sign-extended to 16 bits, so 0x800 reads 0xF800 and 0x7FF reads 0x07FF.
- R6: In 10-bit mode (alt_res_i = 1) positions 5 to 14 carry the sample MSB first. Positions 15 and 16 are ignored, and data_o is the 10-bit sample sign-extended to 16 bits.
- R7: If short_bits_i = n with 1 ≤ n < the mode's width, select rises after 4 + n rising edges. The missing low bits read as zero and reduced_o is 1. Any other n gives a full 16-edge frame with reduced_o = 0.
- R8: Ready is low while select is low. Select stays high for at least QUIET = ceil(QUIET_NS·CLK_MHZ/1000) system cycles before a requested frame begins.
- R9: valid_o pulses for exactly one cycle at the edge on which select rises at the end of each requested frame, together with data_o and reduced_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion (taken when ready_o is high) |
| alt_res_i | input | 1 | 0: 12-bit samples, 1: 10-bit samples |
| short_bits_i | input | NW (4) | Data bits wanted; 0 or ≥ mode width means full frame |
| ready_o | output | 1 | Reader can take a request |
| valid_o | output | 1 | One-cycle pulse: data_o and reduced_o hold a new sample |
| data_o | output | OUT_W (16) | Sign-extended sample |
| reduced_o | output | 1 | Sample came from a shortened frame |
| adc_cs_n_o | output | 1 | Converter select, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_sdo_i | input | 1 | Serial data from the converter |

## Verification
The hardest cases to reach from the ports are the ones where something must be ignored: padding and trailing frame positions, and a start pulse that arrives while a frame is running. The converter model in the bench therefore drives ones into every position the reader must discard. The bench also pulses start in the middle of a frame while it changes the mode and bit-count inputs. Both the sample values and the number of frames seen on select would expose a leak. The throw-away frame after power-up is checked at the ports alone: the bench counts its edges and confirms that no valid pulse appears before ready first rises.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_QUIET
  } rd_state_t;
endpackage

// File: rtl/sar_rd_clkdiv.sv
module sar_rd_clkdiv #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)                 cnt <= '0;
    else if (cnt == CW'(HALF - 1))   cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == CW'(HALF - 1));

  // R3: phases last HALF cycles, so two ticks are never adjacent
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
  parameter int ADC_W = 12,
  parameter int LEAD  = 4,
  parameter int EW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sample,
  input  logic [EW-1:0]    idx,
  input  logic             sdo,
  output logic [ADC_W-1:0] dat
);
  // edge idx (0-based) maps to data bit ADC_W-1-(idx-LEAD); pad edges match none
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dat <= '0;
    end else if (sample) begin
      for (int b = 0; b < ADC_W; b++)
        if (idx == EW'(LEAD + ADC_W - 1 - b)) dat[b] <= sdo;
    end
  end
endmodule

// File: rtl/sar_rd_format.sv
module sar_rd_format #(
  parameter int ADC_W = 12,
  parameter int ALT_W = 10,
  parameter int OUT_W = 16
) (
  input  logic [ADC_W-1:0] dat,
  input  logic             alt_sel,
  output logic [OUT_W-1:0] val
);
  logic [OUT_W-1:0] full_v;
  assign full_v = {{(OUT_W-ADC_W){dat[ADC_W-1]}}, dat};

  generate
    if (ALT_W < ADC_W) begin : g_dual
      logic [OUT_W-1:0] alt_v;
      assign alt_v = {{(OUT_W-ALT_W){dat[ADC_W-1]}}, dat[ADC_W-1 -: ALT_W]};
      assign val   = alt_sel ? alt_v : full_v;
    end else begin : g_single
      assign val = full_v;
    end
  endgenerate
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader #(
  parameter int CLK_MHZ  = 200,
  parameter int SCLK_KHZ = 10000,
  parameter int QUIET_NS = 60,
  parameter int PWRUP_US = 2500,
  parameter int ADC_W    = 12,
  parameter int ALT_W    = 10,
  parameter int LEAD     = 4,
  parameter int OUT_W    = 16,
  localparam int NW      = $clog2(ADC_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             alt_res_i,
  input  logic [NW-1:0]    short_bits_i,
  output logic             ready_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic             reduced_o,
  output logic             adc_cs_n_o,
  output logic             adc_sclk_o,
  input  logic             adc_sdo_i
);
  import sar_rd_pkg::*;

  localparam int FRAME   = LEAD + ADC_W;
  localparam int EW      = $clog2(FRAME + 1);
  localparam int HALF    = (CLK_MHZ * 1000 + 2 * SCLK_KHZ - 1) / (2 * SCLK_KHZ);
  localparam int QRAW    = (QUIET_NS * CLK_MHZ + 999) / 1000;
  localparam int QUIET   = (QRAW < 1) ? 1 : QRAW;
  localparam int PWR     = (PWRUP_US * CLK_MHZ < 1) ? 1 : PWRUP_US * CLK_MHZ;
  localparam int DLY_MAX = (PWR > QUIET) ? PWR : QUIET;
  localparam int DW      = $clog2(DLY_MAX + 1);
  localparam int QW      = $clog2(QUIET + 1);

  rd_state_t        st;
  logic [DW-1:0]    dly;
  logic [EW-1:0]    edges, target;
  logic             alt_q, short_q, dummy_q;
  logic             cs_n_q, sclk_q, ready_q, valid_q, reduced_q;
  logic [OUT_W-1:0] data_q;
  logic             run, tick, cap_clr, sample;
  logic [ADC_W-1:0] dat;
  logic [OUT_W-1:0] fmt_v;
  logic [NW-1:0]    mode_w;
  logic             want_short;

  assign run        = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH);
  assign sample     = (st == ST_LOW) && tick;
  assign cap_clr    = ((st == ST_IDLE) && start_i) ||
                      ((st == ST_PWRUP) && (dly == DW'(PWR - 1)));
  assign mode_w     = alt_res_i ? NW'(ALT_W) : NW'(ADC_W);
  assign want_short = (short_bits_i != '0) && (short_bits_i < mode_w);

  sar_rd_clkdiv #(.HALF(HALF)) i_div (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  sar_rd_capture #(.ADC_W(ADC_W), .LEAD(LEAD), .EW(EW)) i_cap (
    .clk(clk), .rst(rst), .clr(cap_clr), .sample(sample),
    .idx(edges), .sdo(adc_sdo_i), .dat(dat)
  );

  sar_rd_format #(.ADC_W(ADC_W), .ALT_W(ALT_W), .OUT_W(OUT_W)) i_fmt (
    .dat(dat), .alt_sel(alt_q), .val(fmt_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWRUP;
      dly       <= '0;
      edges     <= '0;
      target    <= EW'(FRAME);
      alt_q     <= 1'b0;
      short_q   <= 1'b0;
      dummy_q   <= 1'b0;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b1;
      ready_q   <= 1'b0;
      valid_q   <= 1'b0;
      reduced_q <= 1'b0;
      data_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        ST_PWRUP: begin
          if (dly == DW'(PWR - 1)) begin
            st      <= ST_SETUP;
            cs_n_q  <= 1'b0;
            dummy_q <= 1'b1;
            alt_q   <= 1'b0;
            short_q <= 1'b0;
            target  <= EW'(FRAME);
            edges   <= '0;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        ST_IDLE: begin
          if (start_i) begin
            st      <= ST_SETUP;
            cs_n_q  <= 1'b0;
            ready_q <= 1'b0;
            dummy_q <= 1'b0;
            alt_q   <= alt_res_i;
            short_q <= want_short;
            target  <= want_short ? EW'(LEAD) + EW'(short_bits_i) : EW'(FRAME);
            edges   <= '0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            sclk_q <= 1'b0;
            st     <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk_q <= 1'b1;
            edges  <= edges + 1'b1;
            st     <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (edges == target) begin
              cs_n_q <= 1'b1;
              dly    <= '0;
              st     <= ST_QUIET;
              if (!dummy_q) begin
                valid_q   <= 1'b1;
                data_q    <= fmt_v;
                reduced_q <= short_q;
              end
            end else begin
              sclk_q <= 1'b0;
              st     <= ST_LOW;
            end
          end
        end
        ST_QUIET: begin
          if (dly == DW'(QUIET - 1)) begin
            st      <= ST_IDLE;
            ready_q <= 1'b1;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        default: st <= ST_PWRUP;
      endcase
    end
  end

  assign ready_o    = ready_q;
  assign valid_o    = valid_q;
  assign data_o     = data_q;
  assign reduced_o  = reduced_q;
  assign adc_cs_n_o = cs_n_q;
  assign adc_sclk_o = sclk_q;

  // checker-side count of cycles with select high, saturating at QUIET
  logic [QW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !cs_n_q)            hi_cnt <= '0;
    else if (hi_cnt != QW'(QUIET)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n_o |-> adc_sclk_o);
  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (adc_cs_n_o && hi_cnt >= QW'(QUIET)));
  assert_ready_cs_R8: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n_o |-> !ready_o);
  assert_edge_bound_R4: assert property (@(posedge clk) disable iff (rst)
    edges <= EW'(FRAME));
  assert_valid_end_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($rose(adc_cs_n_o) && !ready_o));
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !alt_q) |->
      (data_o[OUT_W-1:ADC_W-1] == '0 || data_o[OUT_W-1:ADC_W-1] == '1));
  assert_sign_ext_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && alt_q) |->
      (data_o[OUT_W-1:ALT_W-1] == '0 || data_o[OUT_W-1:ALT_W-1] == '1));
  assert_short_len_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && reduced_o) |-> (edges < EW'(FRAME)));
  assert_full_len_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !reduced_o) |-> (edges == EW'(FRAME)));
  assert_dummy_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (dummy_q && !adc_cs_n_o) |-> (!valid_o && !ready_o));
endmodule

// File: tb/test_sar_adc_reader.sv
module test_sar_adc_reader;
  localparam int CLK_MHZ  = 200;
  localparam int SCLK_KHZ = 25000;
  localparam int QUIET_NS = 60;
  localparam int PWRUP_US = 2;
  localparam int HALF     = (CLK_MHZ * 1000 + 2 * SCLK_KHZ - 1) / (2 * SCLK_KHZ);
  localparam int QUIET    = (QUIET_NS * CLK_MHZ + 999) / 1000;
  localparam int PWR      = PWRUP_US * CLK_MHZ;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        alt_res_i = 1'b0;
  logic [3:0]  short_bits_i = '0;
  logic        ready_o, valid_o, reduced_o, adc_cs_n_o, adc_sclk_o;
  logic        adc_sdo_i = 1'b0;
  logic [15:0] data_o;

  always #2.5 clk = ~clk;

  sar_adc_reader #(
    .CLK_MHZ(CLK_MHZ), .SCLK_KHZ(SCLK_KHZ), .QUIET_NS(QUIET_NS), .PWRUP_US(PWRUP_US)
  ) i_sar_adc_reader (
    .clk(clk), .rst(rst), .start_i(start_i), .alt_res_i(alt_res_i),
    .short_bits_i(short_bits_i), .ready_o(ready_o), .valid_o(valid_o),
    .data_o(data_o), .reduced_o(reduced_o), .adc_cs_n_o(adc_cs_n_o),
    .adc_sclk_o(adc_sclk_o), .adc_sdo_i(adc_sdo_i)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // converter model: pad and trailing positions driven as ones
  logic [15:0] cur_fw = 16'hFFFF;
  logic [15:0] fw     = 16'h0;
  int          pos    = 0;
  always @(negedge adc_cs_n_o or negedge adc_sclk_o) begin
    if (adc_sclk_o) begin
      pos = 0; fw = cur_fw; adc_sdo_i = 1'b0;
    end else if (!adc_cs_n_o) begin
      pos++;
      adc_sdo_i = (pos >= 1 && pos <= 16) ? fw[16 - pos] : 1'b0;
    end
  end

  // scoreboard queues
  logic [15:0] q_data[$];
  bit          q_red[$];
  int          q_edges[$];
  string       q_tag[$];
  int          n_req = 0;

  task automatic do_conv(input bit alt, input logic [11:0] s, input int n,
                         input string tag, input bit glitch);
    int          w;
    bit          sh;
    logic [15:0] exp_v;
    logic [11:0] v12;
    logic [9:0]  v10;
    w  = alt ? 10 : 12;
    sh = (n != 0) && (n < w);
    if (alt) begin
      v10 = s[9:0];
      if (sh) v10 = v10 & ~((10'd1 << (10 - n)) - 10'd1);
      exp_v = {{6{v10[9]}}, v10};
      cur_fw = {4'hF, s[9:0], 2'b11};
    end else begin
      v12 = s;
      if (sh) v12 = v12 & ~((12'd1 << (12 - n)) - 12'd1);
      exp_v = {{4{v12[11]}}, v12};
      cur_fw = {4'hF, s};
    end
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    q_data.push_back(exp_v);
    q_red.push_back(sh);
    q_edges.push_back(sh ? 4 + n : 16);
    q_tag.push_back(tag);
    n_req++;
    alt_res_i = alt; short_bits_i = 4'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (glitch) begin
      repeat (20) @(negedge clk);
      alt_res_i = ~alt; short_bits_i = 4'd2; start_i = 1'b1; // R2: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  // monitor
  bit prev_cs = 1, prev_sclk = 1, prev_ready = 0, first_ready = 0;
  int run = 0, hi_run = 0, edges = 0, last_edges = 0, frames = 0, valids = 0;
  always @(negedge clk) begin
    if (!rst) begin
      run++;
      if (adc_cs_n_o) hi_run++;
      if (prev_cs && !adc_cs_n_o) begin
        if (frames == 0)
          chk(hi_run >= PWR - 2 && hi_run <= PWR + 1, "R1", "power-up hold", hi_run, PWR);
        else
          chk(hi_run >= QUIET, "R8", "select high time", hi_run, QUIET);
        chk(!ready_o, "R8", "ready during frame", ready_o, 0);
        edges = 0; run = 0;
      end else if (!prev_cs && adc_cs_n_o) begin
        last_edges = edges; frames++; hi_run = 1;
        chk(adc_sclk_o, "R3", "sclk at select rise", adc_sclk_o, 1);
      end
      if (!adc_cs_n_o && adc_sclk_o != prev_sclk) begin
        chk(run == HALF, "R3", "sclk phase length", run, HALF);
        run = 0;
        if (adc_sclk_o) edges++;
      end
      if (valid_o) begin
        valids++;
        if (q_data.size() == 0) begin
          chk(0, "R2", "unexpected valid", data_o, 0);
        end else begin
          logic [15:0] ed; bit er; int ee; string tg;
          ed = q_data.pop_front(); er = q_red.pop_front();
          ee = q_edges.pop_front(); tg = q_tag.pop_front();
          chk(data_o == ed, tg, "data", data_o, ed);
          chk(reduced_o == er, "R7", "reduced flag", reduced_o, er);
          chk(last_edges == ee, tg, "rising edges in frame", last_edges, ee);
          chk(adc_cs_n_o && !prev_cs, "R9", "valid at select rise", adc_cs_n_o, 1);
        end
      end
      if (ready_o && !prev_ready && !first_ready) begin
        first_ready = 1;
        chk(frames == 1, "R1", "dummy frames", frames, 1);
        chk(last_edges == 16, "R1", "dummy frame edges", last_edges, 16);
        chk(valids == 0, "R1", "valid during dummy", valids, 0);
      end
      prev_cs = adc_cs_n_o; prev_sclk = adc_sclk_o; prev_ready = ready_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(adc_cs_n_o == 1 && adc_sclk_o == 1, "R1", "pins in reset",
        {adc_cs_n_o, adc_sclk_o}, 3);
    chk(ready_o == 0 && valid_o == 0, "R1", "ready/valid in reset",
        {ready_o, valid_o}, 0);
    rst = 1'b0;
    repeat (50) @(negedge clk);
    start_i = 1'b1;                      // R2: start during power-up ignored
    @(negedge clk);
    start_i = 1'b0;
    chk(adc_cs_n_o == 1 && ready_o == 0, "R1", "still powering up",
        {adc_cs_n_o, ready_o}, 2);
    // R4 / R5: 12-bit full frames
    do_conv(0, 12'h7FF, 0, "R5", 0);
    do_conv(0, 12'h800, 0, "R5", 0);
    do_conv(0, 12'h000, 0, "R4", 0);
    do_conv(0, 12'hFFF, 0, "R5", 0);
    do_conv(0, 12'h5A3, 0, "R4", 0);
    // R6: 10-bit frames
    do_conv(1, 12'h1FF, 0, "R6", 0);
    do_conv(1, 12'h200, 0, "R6", 0);
    do_conv(1, 12'h155, 0, "R6", 0);
    do_conv(1, 12'h3FF, 0, "R6", 0);
    // R7: shortened frames and out-of-range counts
    do_conv(0, 12'hABC, 1, "R7", 0);
    do_conv(0, 12'hABC, 6, "R7", 0);
    do_conv(0, 12'h3C7, 11, "R7", 0);
    do_conv(0, 12'h3C7, 12, "R7", 0);
    do_conv(0, 12'h9E1, 15, "R7", 0);
    do_conv(1, 12'h2D6, 3, "R7", 0);
    do_conv(1, 12'h2D6, 9, "R7", 0);
    do_conv(1, 12'h0B5, 10, "R7", 0);
    // R2: start and input changes while busy are ignored
    do_conv(0, 12'h6E9, 0, "R2", 1);
    do_conv(1, 12'h301, 5, "R2", 1);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(frames == n_req + 1, "R2", "frame count", frames, n_req + 1);
    chk(q_data.size() == 0, "R9", "pending samples", q_data.size(), 0);
    chk(valids == n_req, "R9", "valid pulses", valids, n_req);
    finish_run();
  end
endmodule